// File: doc/BRIEF.md
# Burst Address Sequencer with Selectable Wrap Order

This block produces the array address for a synchronous burst memory. On a load cycle it captures an externally supplied address together with the access direction (read or write). On each following advance cycle an internal counter steps through the low address bits and leaves the upper bits as they were loaded. The counter runs in one of two wrap orders, chosen by a static mode input. The linear order adds the beat count to the start value. The interleaved order XORs the beat count into the start value.

The control inputs are an advance/load strobe, three chip selects (two active-low, one active-high) and an active-low write strobe. They decode into one of five operations: stall, load, deselect, continue, and continue-deselect. The write direction is latched at load time and stays fixed for the whole burst. Chip selects and the write strobe are not examined while a burst continues. Once the block is deselected, only a load brings it back. A hold input freezes every register. It acts as an active-high clock qualifier.

The outputs are the current address, a valid flag for the access in progress, and the latched access type. The storage array itself is outside this block.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is applied, and directly after it, `addr_out` is zero, `acc_valid` is 0 and `acc_write` is 0.
- R2: A load has `step_adv`=0, `cs0_n`=0, `cs1`=1 and `cs2_n`=0 at an edge where `hold`=0. After the edge, `addr_out` equals the captured `addr_in`, `acc_valid`=1, and `acc_write`=1 exactly when `wr_n` was 0.
- R3: Any other value on a select at a load edge (`cs0_n`=1, `cs1`=0 or `cs2_n`=1) is a deselect. After that edge, `acc_valid`=0 and `acc_write`=0, and `addr_out` keeps its previous value.
- R4: With `order_ilv`=0 (linear), the low `BURST_W` bits after a load starting at s run through s+1, s+2, s+3 on successive advances, modulo 2^`BURST_W`.
- R5: With `order_ilv`=1 (interleaved), the low bits run through s^1, s^2, s^3 on successive advances. For example, a start of 01 gives 01, 00, 11, 10.
- R6: During advances the bits of `addr_out` above the low `BURST_W` bits keep their loaded value. After 2^`BURST_W` advances the low bits return to the start value, and no error is signalled.
- R7: During an advance of a valid burst, `cs0_n`, `cs1`, `cs2_n` and `wr_n` have no effect. `acc_valid` stays 1 and `acc_write` keeps the type latched at load.
- R8: An advance while deselected leaves `acc_valid`=0, `acc_write`=0 and `addr_out` unchanged, whatever the select and write inputs are.
- R9: An edge with `hold`=1 changes none of `addr_out`, `acc_valid` or `acc_write`, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | 1 freezes all state at this edge |
| step_adv | input | 1 | 0 = load a new address, 1 = advance the burst |
| cs0_n | input | 1 | Chip select, active low |
| cs1 | input | 1 | Chip select, active high |
| cs2_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | 0 = write, 1 = read; sampled at load only |
| order_ilv | input | 1 | Static mode: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | External start address |
| addr_out | output | ADDR_W | Current array address |
| acc_valid | output | 1 | An access is in progress |
| acc_write | output | 1 | Latched access type, 1 = write |

## Verification
The bench builds the block with `ADDR_W`=12 and `BURST_W`=2. A 12-bit address gives distinct upper bits that can be watched for corruption across a wrap. A two-bit counter lets a full four-beat burst, and its return to the start value, run in a few cycles. At this size both wrap orders can be checked beat by beat from several start values. That includes a start of 11, where the linear carry must stop at the low bits. The same size also reaches the deselect, continue-deselect and hold cases within a short sequence.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  typedef enum logic [2:0] {
    OP_STALL     = 3'd0,
    OP_LOAD      = 3'd1,
    OP_DESEL     = 3'd2,
    OP_STEP      = 3'd3,
    OP_IDLE_STEP = 3'd4
  } seq_op_e;

endpackage

// File: rtl/bseq_decode.sv
module bseq_decode
  import bseq_pkg::*;
(
  input  logic    hold,
  input  logic    step_adv,
  input  logic    cs0_n,
  input  logic    cs1,
  input  logic    cs2_n,
  input  logic    cur_valid,
  output seq_op_e op
);

  logic sel_all;

  assign sel_all = ~cs0_n & cs1 & ~cs2_n;

  always_comb begin
    op = OP_STALL;
    if (hold) begin
      op = OP_STALL;
    end else if (!step_adv) begin
      op = sel_all ? OP_LOAD : OP_DESEL;
    end else begin
      op = cur_valid ? OP_STEP : OP_IDLE_STEP;
    end
  end

endmodule

// File: rtl/bseq_order.sv
module bseq_order #(
  parameter int BURST_W = 2
) (
  input  logic               ilv,
  input  logic [BURST_W-1:0] start,
  input  logic [BURST_W-1:0] beat,
  output logic [BURST_W-1:0] low
);

  logic [BURST_W-1:0] lin_low;
  logic [BURST_W-1:0] xor_low;

  assign lin_low = start + beat;
  assign xor_low = start ^ beat;

  always_comb begin
    if (ilv) low = xor_low;
    else     low = lin_low;
  end

endmodule

// File: rtl/bseq_state.sv
module bseq_state
  import bseq_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_op_e           op,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              wr_n,
  output logic [ADDR_W-1:0] base_q,
  output logic [BURST_W-1:0] beat_q,
  output logic              valid_q,
  output logic              write_q
);

  logic [ADDR_W-1:0]  base_d;
  logic [BURST_W-1:0] beat_d;
  logic               valid_d;
  logic               write_d;
  logic               upd_en;

  assign upd_en = (op != OP_STALL);

  always_comb begin
    base_d  = base_q;
    beat_d  = beat_q;
    valid_d = valid_q;
    write_d = write_q;
    case (op)
      OP_LOAD: begin
        base_d  = addr_in;
        beat_d  = '0;
        valid_d = 1'b1;
        write_d = ~wr_n;
      end
      OP_DESEL: begin
        valid_d = 1'b0;
        write_d = 1'b0;
      end
      OP_STEP: begin
        beat_d = beat_q + BURST_W'(1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      beat_q  <= '0;
      valid_q <= 1'b0;
      write_q <= 1'b0;
    end else if (upd_en) begin
      base_q  <= base_d;
      beat_q  <= beat_d;
      valid_q <= valid_d;
      write_q <= write_d;
    end
  end

  // R9: a stalled edge leaves every register untouched
  p_stall_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_STALL) |=> ($stable(base_q) && $stable(beat_q) &&
                          $stable(valid_q) && $stable(write_q)));

  // R4 / R5: one beat per continue cycle
  p_beat_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_STEP) |=> (beat_q == $past(beat_q) + BURST_W'(1)));

  // R8: continue-deselect keeps the address state
  p_idle_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_IDLE_STEP) |=> ($stable(base_q) && $stable(beat_q) && !valid_q));

  // R3: a write type never exists without a valid access
  p_write_needs_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    write_q |-> valid_q);

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int ADDR_W  = 17,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              step_adv,
  input  logic              cs0_n,
  input  logic              cs1,
  input  logic              cs2_n,
  input  logic              wr_n,
  input  logic              order_ilv,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              acc_valid,
  output logic              acc_write
);

  localparam int UPPER_LSB = BURST_W;

  seq_op_e            op;
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] beat_q;
  logic [BURST_W-1:0] low_bits;
  logic               valid_q;
  logic               write_q;

  bseq_decode u_decode (
    .hold      (hold),
    .step_adv  (step_adv),
    .cs0_n     (cs0_n),
    .cs1       (cs1),
    .cs2_n     (cs2_n),
    .cur_valid (valid_q),
    .op        (op)
  );

  bseq_state #(
    .ADDR_W  (ADDR_W),
    .BURST_W (BURST_W)
  ) u_state (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (op),
    .addr_in (addr_in),
    .wr_n    (wr_n),
    .base_q  (base_q),
    .beat_q  (beat_q),
    .valid_q (valid_q),
    .write_q (write_q)
  );

  bseq_order #(
    .BURST_W (BURST_W)
  ) u_order (
    .ilv   (order_ilv),
    .start (base_q[BURST_W-1:0]),
    .beat  (beat_q),
    .low   (low_bits)
  );

  assign addr_out  = {base_q[ADDR_W-1:UPPER_LSB], low_bits};
  assign acc_valid = valid_q;
  assign acc_write = write_q;

  // R2: a selected load presents the captured address and type
  p_load_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !step_adv && !cs0_n && cs1 && !cs2_n)
      |=> (acc_valid && addr_out == $past(addr_in) && acc_write == !$past(wr_n)));

  // R3: an unselected load ends any access
  p_desel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !step_adv && (cs0_n || !cs1 || cs2_n)) |=> (!acc_valid && !acc_write));

  // R7: advance keeps the valid flag and the latched type
  p_adv_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && step_adv) |=> ($stable(acc_valid) && $stable(acc_write)));

  // R6: advances never touch the upper address bits
  p_upper_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && step_adv) |=> (addr_out[ADDR_W-1:UPPER_LSB] == $past(addr_out[ADDR_W-1:UPPER_LSB])));

endmodule

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;

  localparam int PERIOD  = 10;
  localparam int ADDR_W  = 12;
  localparam int BURST_W = 2;

  logic              clk;
  logic              rst_n;
  logic              hold;
  logic              step_adv;
  logic              cs0_n;
  logic              cs1;
  logic              cs2_n;
  logic              wr_n;
  logic              order_ilv;
  logic [ADDR_W-1:0] addr_in;
  logic [ADDR_W-1:0] addr_out;
  logic              acc_valid;
  logic              acc_write;

  int n_tests;
  int n_fail;

  logic [ADDR_W-1:0] q_addr[$];
  logic              q_valid[$];
  logic              q_write[$];
  string             q_tag[$];

  burst_addr_seq #(
    .ADDR_W  (ADDR_W),
    .BURST_W (BURST_W)
  ) uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold      (hold),
    .step_adv  (step_adv),
    .cs0_n     (cs0_n),
    .cs1       (cs1),
    .cs2_n     (cs2_n),
    .wr_n      (wr_n),
    .order_ilv (order_ilv),
    .addr_in   (addr_in),
    .addr_out  (addr_out),
    .acc_valid (acc_valid),
    .acc_write (acc_write)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  // Driver: applies one cycle of inputs and queues the result expected after the next edge
  task automatic cyc(input logic h, input logic adv, input logic c0n, input logic c1,
                     input logic c2n, input logic wn, input logic ilv,
                     input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] ea,
                     input logic ev, input logic ew, input string tag);
    @(negedge clk);
    hold = h; step_adv = adv; cs0_n = c0n; cs1 = c1; cs2_n = c2n;
    wr_n = wn; order_ilv = ilv; addr_in = a;
    q_addr.push_back(ea);
    q_valid.push_back(ev);
    q_write.push_back(ew);
    q_tag.push_back(tag);
  endtask

  // Monitor: compares the queue head shortly after each rising edge
  always @(posedge clk) begin
    #(PERIOD/4);
    if (q_addr.size() > 0) begin
      logic [ADDR_W-1:0] ea;
      logic ev;
      logic ew;
      string tg;
      ea = q_addr.pop_front();
      ev = q_valid.pop_front();
      ew = q_write.pop_front();
      tg = q_tag.pop_front();
      n_tests++;
      if (addr_out !== ea || acc_valid !== ev || acc_write !== ew) begin
        n_fail++;
        $display("FAIL %s: got addr=%h valid=%b write=%b, expected addr=%h valid=%b write=%b",
                 tg, addr_out, acc_valid, acc_write, ea, ev, ew);
      end
    end
  end

  initial begin
    #(PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    n_tests = 0; n_fail = 0;
    rst_n = 1'b0; hold = 1'b0; step_adv = 1'b0; cs0_n = 1'b0; cs1 = 1'b1;
    cs2_n = 1'b0; wr_n = 1'b0; order_ilv = 1'b0; addr_in = 12'hABC;
    repeat (3) @(posedge clk);
    #(PERIOD/4);
    n_tests++; // R1 during reset
    if (addr_out !== '0 || acc_valid !== 1'b0 || acc_write !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: got addr=%h valid=%b write=%b, expected addr=000 valid=0 write=0",
               addr_out, acc_valid, acc_write);
    end
    @(negedge clk);
    hold = 1'b1;
    rst_n = 1'b1;
    // R1 after release, with a held edge
    cyc(1, 0, 0, 1, 0, 0, 0, 12'h123, 12'h000, 0, 0, "R1");

    // R2 load read, R4 linear steps, R6 wrap
    cyc(0, 0, 0, 1, 0, 1, 0, 12'h5A1, 12'h5A1, 1, 0, "R2");
    cyc(0, 1, 0, 1, 0, 1, 0, 12'h000, 12'h5A2, 1, 0, "R4");
    cyc(0, 1, 0, 1, 0, 1, 0, 12'h000, 12'h5A3, 1, 0, "R4");
    cyc(0, 1, 0, 1, 0, 1, 0, 12'h000, 12'h5A0, 1, 0, "R4");
    cyc(0, 1, 0, 1, 0, 1, 0, 12'h000, 12'h5A1, 1, 0, "R6");

    // R2 load write, R5 interleaved with R7 ignored selects and write strobe
    cyc(0, 0, 0, 1, 0, 0, 1, 12'h3C6, 12'h3C6, 1, 1, "R2");
    cyc(0, 1, 1, 0, 1, 1, 1, 12'h000, 12'h3C7, 1, 1, "R7");
    cyc(0, 1, 0, 1, 0, 1, 1, 12'h000, 12'h3C4, 1, 1, "R5");
    cyc(0, 1, 1, 1, 0, 1, 1, 12'h000, 12'h3C5, 1, 1, "R5");
    cyc(0, 1, 0, 1, 0, 0, 1, 12'h000, 12'h3C6, 1, 1, "R6");

    // R9 hold ignores a load and an advance
    cyc(1, 0, 0, 1, 0, 1, 1, 12'h111, 12'h3C6, 1, 1, "R9");
    cyc(1, 1, 0, 1, 0, 1, 1, 12'h111, 12'h3C6, 1, 1, "R9");

    // R3 each select deasserted, R8 advance while deselected
    cyc(0, 0, 0, 0, 0, 0, 1, 12'h222, 12'h3C6, 0, 0, "R3");
    cyc(0, 1, 0, 1, 0, 0, 1, 12'h333, 12'h3C6, 0, 0, "R8");
    cyc(0, 1, 0, 1, 0, 0, 1, 12'h333, 12'h3C6, 0, 0, "R8");
    cyc(0, 0, 0, 1, 0, 0, 1, 12'h444, 12'h444, 1, 1, "R2");
    cyc(0, 0, 1, 1, 0, 0, 1, 12'h555, 12'h444, 0, 0, "R3");
    cyc(0, 0, 0, 1, 0, 0, 1, 12'h444, 12'h444, 1, 1, "R2");
    cyc(0, 0, 0, 1, 1, 0, 1, 12'h666, 12'h444, 0, 0, "R3");

    // R5 start 01: 01, 00, 11, 10, with a hold mid-burst (R9) then wrap (R6)
    cyc(0, 0, 0, 1, 0, 0, 1, 12'h0FD, 12'h0FD, 1, 1, "R5");
    cyc(0, 1, 0, 1, 0, 0, 1, 12'h000, 12'h0FC, 1, 1, "R5");
    cyc(0, 1, 0, 1, 0, 0, 1, 12'h000, 12'h0FF, 1, 1, "R5");
    cyc(0, 1, 0, 1, 0, 0, 1, 12'h000, 12'h0FE, 1, 1, "R5");
    cyc(1, 1, 0, 1, 0, 0, 1, 12'h000, 12'h0FE, 1, 1, "R9");
    cyc(0, 1, 0, 1, 0, 0, 1, 12'h000, 12'h0FD, 1, 1, "R6");

    // R4 / R6 linear start 11: carry must not reach upper bits
    cyc(0, 0, 0, 1, 0, 1, 0, 12'h7FF, 12'h7FF, 1, 0, "R4");
    cyc(0, 1, 0, 1, 0, 0, 0, 12'h000, 12'h7FC, 1, 0, "R6");
    cyc(0, 1, 0, 1, 0, 0, 0, 12'h000, 12'h7FD, 1, 0, "R4");

    @(negedge clk);
    hold = 1'b1;
    repeat (3) @(posedge clk);
    #(PERIOD/2);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule